// File: doc/BRIEF.md
# Signed Double-Width Sequential Divider

This block divides a signed dividend twice as wide as the operand by a signed divisor one operand wide. It returns a quotient and a remainder, each one operand wide. The operand width is picked for each operation with a size code: 8, 16, 32 or 64 bits. The caller raises `start` with the operands while the block is idle. After a number of cycles set by the width, a one-cycle `done` pulse marks that the results are ready. Division by zero, and a quotient that cannot be represented at the selected width, are both reported on the single `div_err` output. In that case the previous results are left untouched.

Internally the operands are converted to magnitudes. A restoring shift-subtract loop then produces one quotient bit per cycle, and a final cycle applies the signs and checks the signed range. When the upper half of the dividend magnitude is already at least the divisor magnitude, the quotient needs more bits than the destination holds. That case skips the loop entirely.

Top module: `sdiv_wide`

## Requirements
- R1: Size code 0, 1, 2 and 3 selects operand width n = 8, 16, 32 and 64. Only the low 2n bits of `dividend` and the low n bits of `divisor` are used, each read as two's complement. `quotient` and `remainder` are the n-bit results sign-extended to 64 bits.
- R2: A zero divisor raises `div_err` together with `done`, and `quotient`/`remainder` keep the values they had before the operation.
- R3: The quotient is rounded toward zero for every combination of operand signs.
- R4: On a successful operation the magnitude of the remainder is strictly less than the magnitude of the divisor.
- R5: On success the remainder is zero or has the sign of the dividend, so that dividend = quotient × divisor + remainder exactly.
- R6: A true quotient greater than 2^(n-1)-1 raises `div_err` and commits no result.
- R7: A true quotient below -2^(n-1) raises `div_err`. A quotient of exactly -2^(n-1) is a valid result.
- R8: `start` is accepted only while `busy` is low, and `busy` is high in the cycle after acceptance. A `start` seen while busy is ignored and does not change the running operation.
- R9: `done` is high for exactly one cycle. Take k as the accepting clock edge. For an operation whose quotient magnitude is below 2^n, `done` follows clock edge k+n+1. For a zero divisor, or a quotient magnitude of 2^n or more, `done` follows edge k+1. `busy` falls with `done`.
- R10: After reset, `busy`, `done` and `div_err` are low and `quotient` and `remainder` are zero.
- R11: `quotient`, `remainder` and `div_err` change only in the cycle where `done` rises, except that `div_err` clears when a new `start` is accepted. Otherwise they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; sampled while idle |
| op_size | input | 2 | Operand width code (0:8, 1:16, 2:32, 3:64) |
| dividend | input | 128 | Signed dividend, low 2n bits used |
| divisor | input | 64 | Signed divisor, low n bits used |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Zero divisor or quotient out of range |
| quotient | output | 64 | Signed quotient, sign-extended from n bits |
| remainder | output | 64 | Signed remainder, sign-extended from n bits |

## Verification
At every width, each of the four sign combinations of a small dividend and divisor is run. This separates truncation toward zero from floor rounding and shows which operand the remainder takes its sign from. Quotients placed exactly at +2^(n-1)-1 and -2^(n-1), and one step beyond each, show that the range check is asymmetric. They also separate an overflow caught before the loop (most negative dividend over -1, quotient of 2^n) from one found after it, which the timing of `done` exposes. Random full-width dividends with junk in unused upper bits, random narrow dividends, zero divisors between good results, and `start` pulses during a run show that the unused bits, stale results and the handshake all behave.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } sdiv_state_e;

endpackage

// File: rtl/sdiv_prep.sv
// Operand conditioning: sign-extend per width, take magnitudes, split the
// dividend into the upper half (initial partial remainder) and a left-aligned
// lower half, and flag quotients too wide before any iteration.
module sdiv_prep #(
  parameter  int MIN_W     = 8,
  parameter  int NUM_SIZES = 4,
  localparam int XLEN      = MIN_W << (NUM_SIZES - 1),
  localparam int SZW       = $clog2(NUM_SIZES),
  localparam int CW        = $clog2(XLEN + 1)
) (
  input  logic [SZW-1:0]    size,
  input  logic [2*XLEN-1:0] dvd,
  input  logic [XLEN-1:0]   dvs,
  output logic [XLEN-1:0]   hi_mag,
  output logic [XLEN-1:0]   lo_al,
  output logic [XLEN-1:0]   dvs_mag,
  output logic              dvd_neg,
  output logic              dvs_neg,
  output logic              early_ovf,
  output logic [CW-1:0]     width_n
);

  logic [2*XLEN-1:0] dvd_sx [NUM_SIZES];
  logic [XLEN-1:0]   dvs_sx [NUM_SIZES];
  logic              dvd_sg [NUM_SIZES];
  logic              dvs_sg [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
    localparam int W = MIN_W << s;
    assign dvd_sg[s] = dvd[2*W-1];
    assign dvs_sg[s] = dvs[W-1];
    if (W == XLEN) begin : g_full
      assign dvd_sx[s] = dvd;
      assign dvs_sx[s] = dvs;
    end else begin : g_ext
      assign dvd_sx[s] = {{(2*XLEN-2*W){dvd[2*W-1]}}, dvd[2*W-1:0]};
      assign dvs_sx[s] = {{(XLEN-W){dvs[W-1]}}, dvs[W-1:0]};
    end
  end

  logic [2*XLEN-1:0] dsel;
  logic [2*XLEN-1:0] dmag;
  logic [2*XLEN-1:0] dshift;
  logic [XLEN-1:0]   vsel;
  logic [XLEN-1:0]   lo_mask;
  logic [XLEN-1:0]   lo_raw;

  always_comb begin
    width_n  = CW'(MIN_W) << size;
    dsel     = dvd_sx[size];
    dvd_neg  = dvd_sg[size];
    dmag     = dvd_neg ? (~dsel + 1'b1) : dsel;
    dshift   = dmag >> width_n;
    hi_mag   = dshift[XLEN-1:0];
    lo_mask  = ~({XLEN{1'b1}} << width_n);
    lo_raw   = dmag[XLEN-1:0] & lo_mask;
    lo_al    = lo_raw << (CW'(XLEN) - width_n);
    vsel     = dvs_sx[size];
    dvs_neg  = dvs_sg[size];
    dvs_mag  = dvs_neg ? (~vsel + 1'b1) : vsel;
    // quotient magnitude >= 2^n, also true for a zero divisor
    early_ovf = (hi_mag >= dvs_mag) | (|dshift[2*XLEN-1:XLEN]);
  end

endmodule

// File: rtl/sdiv_core.sv
// Restoring shift-subtract loop on magnitudes, one quotient bit per step.
module sdiv_core #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [XLEN-1:0] hi_in,
  input  logic [XLEN-1:0] lo_in,
  input  logic [XLEN-1:0] m_in,
  output logic [XLEN-1:0] rem_mag,
  output logic [XLEN-1:0] quo_mag,
  output logic [XLEN-1:0] dvs_mag
);

  logic [XLEN-1:0] r_q, r_d;
  logic [XLEN-1:0] q_q, q_d;
  logic [XLEN-1:0] m_q, m_d;
  logic [XLEN:0]   trial;
  logic [XLEN-1:0] diff;
  logic            fits;
  logic            reg_en;

  always_comb begin
    trial  = {r_q, q_q[XLEN-1]};
    fits   = trial >= {1'b0, m_q};
    diff   = trial[XLEN-1:0] - m_q;
    reg_en = load | step;
    r_d    = r_q;
    q_d    = q_q;
    m_d    = m_q;
    if (load) begin
      r_d = hi_in;
      q_d = lo_in;
      m_d = m_in;
    end else if (step) begin
      r_d = fits ? diff : trial[XLEN-1:0];
      q_d = {q_q[XLEN-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= '0;
      q_q <= '0;
      m_q <= '0;
    end else if (reg_en) begin
      r_q <= r_d;
      q_q <= q_d;
      m_q <= m_d;
    end
  end

  assign rem_mag = r_q;
  assign quo_mag = q_q;
  assign dvs_mag = m_q;

endmodule

// File: rtl/sdiv_post.sv
// Sign restoration and signed range check of the unsigned quotient magnitude.
module sdiv_post #(
  parameter int XLEN = 64,
  parameter int CW   = 7
) (
  input  logic [XLEN-1:0] qmag,
  input  logic [XLEN-1:0] rmag,
  input  logic            q_neg,
  input  logic            r_neg,
  input  logic [CW-1:0]   width_n,
  output logic [XLEN-1:0] q_fix,
  output logic [XLEN-1:0] r_fix,
  output logic            late_ovf
);

  logic [XLEN-1:0] half;

  always_comb begin
    half     = {{(XLEN-1){1'b0}}, 1'b1} << (width_n - 1'b1);
    late_ovf = q_neg ? (qmag > half) : (qmag >= half);
    q_fix    = q_neg ? (~qmag + 1'b1) : qmag;
    r_fix    = r_neg ? (~rmag + 1'b1) : rmag;
  end

endmodule

// File: rtl/sdiv_wide.sv
module sdiv_wide #(
  parameter  int MIN_W     = 8,
  parameter  int NUM_SIZES = 4,
  localparam int XLEN      = MIN_W << (NUM_SIZES - 1),
  localparam int SZW       = $clog2(NUM_SIZES),
  localparam int CW        = $clog2(XLEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SZW-1:0]    op_size,
  input  logic [2*XLEN-1:0] dividend,
  input  logic [XLEN-1:0]   divisor,
  output logic              busy,
  output logic              done,
  output logic              div_err,
  output logic [XLEN-1:0]   quotient,
  output logic [XLEN-1:0]   remainder
);
  import sdiv_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  // operand conditioning
  logic [XLEN-1:0] hi_mag, lo_al, m_in;
  logic            dvd_neg, dvs_neg, early_ovf;
  logic [CW-1:0]   width_n;

  sdiv_prep #(.MIN_W(MIN_W), .NUM_SIZES(NUM_SIZES)) u_prep (
    .size      (op_size),
    .dvd       (dividend),
    .dvs       (divisor),
    .hi_mag    (hi_mag),
    .lo_al     (lo_al),
    .dvs_mag   (m_in),
    .dvd_neg   (dvd_neg),
    .dvs_neg   (dvs_neg),
    .early_ovf (early_ovf),
    .width_n   (width_n)
  );

  // control state
  sdiv_state_e     st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [SZW-1:0]  size_q, size_d;
  logic            qneg_q, qneg_d;
  logic            rneg_q, rneg_d;
  logic            early_q, early_d;
  logic            done_q, done_d;
  logic            err_q, err_d;
  logic [XLEN-1:0] quo_q, quo_d;
  logic [XLEN-1:0] rem_q, rem_d;
  logic            load, step, cap_en, out_en, fault;

  logic [XLEN-1:0] rem_mag, quo_mag, dvs_mag;

  sdiv_core #(.XLEN(XLEN)) u_core (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .load    (load),
    .step    (step),
    .hi_in   (hi_mag),
    .lo_in   (lo_al),
    .m_in    (m_in),
    .rem_mag (rem_mag),
    .quo_mag (quo_mag),
    .dvs_mag (dvs_mag)
  );

  logic [CW-1:0]   n_q;
  logic [XLEN-1:0] q_fix, r_fix;
  logic            late_ovf;

  assign n_q = CW'(MIN_W) << size_q;

  sdiv_post #(.XLEN(XLEN), .CW(CW)) u_post (
    .qmag     (quo_mag),
    .rmag     (rem_mag),
    .q_neg    (qneg_q),
    .r_neg    (rneg_q),
    .width_n  (n_q),
    .q_fix    (q_fix),
    .r_fix    (r_fix),
    .late_ovf (late_ovf)
  );

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    size_d  = size_q;
    qneg_d  = qneg_q;
    rneg_d  = rneg_q;
    early_d = early_q;
    err_d   = err_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    done_d  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    cap_en  = 1'b0;
    out_en  = 1'b0;
    fault   = early_q | late_ovf;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          cap_en  = 1'b1;
          size_d  = op_size;
          qneg_d  = dvd_neg ^ dvs_neg;
          rneg_d  = dvd_neg;
          early_d = early_ovf;
          err_d   = 1'b0;
          cnt_d   = width_n;
          st_d    = early_ovf ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        step  = 1'b1;
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) st_d = ST_FIN;
      end
      ST_FIN: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        err_d  = fault;
        if (!fault) begin
          out_en = 1'b1;
          quo_d  = q_fix;
          rem_d  = r_fix;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      size_q  <= '0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      early_q <= 1'b0;
    end else if (cap_en) begin
      size_q  <= size_d;
      qneg_q  <= qneg_d;
      rneg_q  <= rneg_d;
      early_q <= early_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      quo_q <= '0;
      rem_q <= '0;
    end else if (out_en) begin
      quo_q <= quo_d;
      rem_q <= rem_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign div_err   = err_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;

endmodule

// File: rtl/sdiv_wide_chk.sv
module sdiv_wide_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            div_err,
  input logic [XLEN-1:0] quotient,
  input logic [XLEN-1:0] remainder,
  input logic [XLEN-1:0] dvs_mag,
  input logic            rneg
);

  logic [XLEN-1:0] rem_abs;
  assign rem_abs = remainder[XLEN-1] ? (~remainder + 1'b1) : remainder;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_err) |-> ($stable(quotient) && $stable(remainder)));

  // R4
  rem_lt_dvs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_err) |-> (rem_abs < dvs_mag));

  // R5
  rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_err && remainder != '0) |-> (remainder[XLEN-1] == rneg));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(quotient) || !$stable(remainder)) |-> done);

endmodule

bind sdiv_wide sdiv_wide_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_i_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .div_err   (div_err),
  .quotient  (quotient),
  .remainder (remainder),
  .dvs_mag   (dvs_mag),
  .rneg      (rneg_q)
);

// File: tb/sim_sdiv_wide.sv
module sim_sdiv_wide;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   sz = 2'd0;
  logic [127:0] dvd = '0;
  logic [63:0]  dvs = '0;
  logic         busy, done, div_err;
  logic [63:0]  quotient, remainder;

  int    total = 0;
  int    bad = 0;
  bit    checking = 1'b0;
  string cur_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  sdiv_wide u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_size(sz),
    .dividend(dvd), .divisor(dvs), .busy(busy), .done(done),
    .div_err(div_err), .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: wide signed arithmetic
  task automatic ref_div(input int s, input logic [127:0] a_in, input logic [63:0] b_in,
                         output bit err, output bit early,
                         output logic [63:0] q, output logic [63:0] r);
    int n = 8 << s;
    logic signed [129:0] t, a, b, qq, rr, aq, lim;
    t = {2'b00, a_in};
    t = t <<< (130 - 2*n);
    a = t >>> (130 - 2*n);
    t = {66'd0, b_in};
    t = t <<< (130 - n);
    b = t >>> (130 - n);
    lim = 130'sd1 <<< (n - 1);
    q = '0; r = '0;
    if (b == 0) begin
      err = 1'b1; early = 1'b1;
    end else begin
      qq = a / b;
      rr = a % b;
      aq = (qq < 0) ? -qq : qq;
      early = (aq >= (130'sd1 <<< n));
      err = (qq > lim - 1) || (qq < -lim);
      q = qq[63:0];
      r = rr[63:0];
    end
  endtask

  // cycle model
  bit          m_busy, m_done, m_err, p_err;
  int          m_cnt;
  logic [63:0] m_q, m_r, p_q, p_r;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_err <= 0; m_cnt <= 0;
      m_q <= '0; m_r <= '0; p_err <= 0; p_q <= '0; p_r <= '0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy && start) begin
        bit e, ea; logic [63:0] eq, er;
        ref_div(int'(sz), dvd, dvs, e, ea, eq, er);
        m_busy <= 1'b1;
        m_cnt  <= ea ? 1 : (8 << sz) + 1;
        m_err  <= 1'b0;
        p_err  <= e; p_q <= eq; p_r <= er;
      end else if (m_busy) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
          m_err  <= p_err;
          if (!p_err) begin m_q <= p_q; m_r <= p_r; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      chk("R8", "busy", 128'(busy), 128'(m_busy));
      chk("R9", "done", 128'(done), 128'(m_done));
      chk(cur_tag, "div_err", 128'(div_err), 128'(m_err));
      chk(cur_tag, "quotient", 128'(quotient), 128'(m_q));
      chk(cur_tag, "remainder", 128'(remainder), 128'(m_r));
    end
  end

  task automatic do_op(string tag, int s, logic [127:0] a, logic [63:0] b);
    int guard = 0;
    @(negedge clk);
    while (busy) @(negedge clk);
    cur_tag = tag;
    start = 1'b1; sz = 2'(s); dvd = a; dvs = b;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 300) begin @(negedge clk); guard++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] one = 128'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10", "busy", 128'(busy), 0);
    chk("R10", "done", 128'(done), 0);
    chk("R10", "div_err", 128'(div_err), 0);
    chk("R10", "quotient", 128'(quotient), 0);
    chk("R10", "remainder", 128'(remainder), 0);
    checking = 1'b1;

    for (int s = 0; s < 4; s++) begin
      int n = 8 << s;
      // R3 four sign combinations
      do_op("R3", s, 128'd7, 64'd2);
      do_op("R3", s, -128'd7, 64'd2);
      do_op("R3", s, 128'd7, -64'd2);
      do_op("R3", s, -128'd7, -64'd2);
      // R5 remainder sign follows dividend
      do_op("R5", s, -128'd100, 64'd7);
      // R2 zero divisor keeps previous results
      do_op("R2", s, 128'd100, 64'd0);
      // R6 positive limit
      do_op("R6", s, (one << (n-1)) - 1, 64'd1);
      do_op("R6", s, one << (n-1), 64'd1);
      do_op("R6", s, one << n, 64'd1);
      // R7 negative limit
      do_op("R7", s, -(one << (n-1)), 64'd1);
      do_op("R7", s, one << (n-1), -64'd1);
      do_op("R7", s, -(one << (n-1)) - 1, 64'd1);
      do_op("R7", s, -(one << (2*n-1)), -64'd1);
    end

    // R1 junk above the selected width
    do_op("R1", 0, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5A5A_FF9C, 64'hFEDC_BA98_7654_3207);
    do_op("R1", 1, 128'hABCD_0000_1111_2222_3333_4444_FFFF_FC18, 64'h7777_8888_9999_0021);

    // R8 start pulses during a run are ignored
    do_op("R8", 3, 128'd123456789, 64'd1000);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; sz = 2'd3; dvd = -128'd999999; dvs = 64'd77;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      sz = 2'd0; dvd = 128'd5; dvs = 64'd0;
      @(negedge clk);
    end
    start = 1'b0;
    while (!done) @(negedge clk);

    // R11 outputs and error hold while idle
    do_op("R11", 2, 128'd50, 64'd0);
    cur_tag = "R11";
    repeat (10) @(negedge clk);

    // R4 random operands at every width
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 40; k++) begin
        int n = 8 << s;
        logic [127:0] a;
        logic [63:0]  b;
        b = {$urandom, $urandom};
        if (($urandom % 4) == 0) b = b >> ($urandom % 64);
        if (($urandom % 2) == 0) begin
          a = {$urandom, $urandom, $urandom, $urandom};
        end else begin
          a = {$urandom, $urandom, $urandom, $urandom};
          a = 128'($signed(a << (128 - n)) >>> (128 - n));
        end
        do_op("R4", s, a, b);
      end
    end

    repeat (3) @(negedge clk);
    checking = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule